// File: doc/BRIEF.md
# Spare-Block Redundancy Steering RAM

This block is one slice of a cache data array. It holds four primary storage blocks, each 16 bits wide and 32 rows deep, and one spare block of the same shape. It offers two ports that share one row address. A 64-bit wide port moves whole rows to and from the next memory level, with all four blocks side by side. A 4-bit narrow port serves the processor: it picks one nibble position within a block, then picks one block's nibble.

A repair register is loaded once at start-up. It names one logical block whose traffic moves to the spare, or it names none. While repair is on, reads of that block come from the spare on both ports. The spare's write input takes the 16-bit logical bus of the named block, and the failed primary is no longer written. While repair is off, the spare plays no part at all.

Both ports have one cycle of read latency. The two ports are not meant to be used in the same cycle. If they are, the wide access is carried out and the narrow access is dropped.

Top module: `spare_steer_ram`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, repair is off and wide_rdata and nib_rdata are zero.
- R2: A cycle with cfg_load high stores cfg_en as the repair enable and cfg_idx (0 to 3) as the repaired logical block. The stored setting takes effect in the next cycle and holds while cfg_load is low.
- R3: A wide read (wide_en=1, wide_we=0) presents the row at addr on wide_rdata one cycle later. Bits [16b+15:16b] carry logical block b. That lane comes from the spare when repair is on and b is the repaired block, and from primary block b otherwise.
- R4: A wide write (wide_en=1, wide_we=1) stores lane b of wide_wdata into row addr of logical block b, for all four blocks. When repair is on, the repaired lane goes to the spare and its primary block is left unchanged.
- R5: A narrow read (nib_en=1, nib_we=0, wide_en=0) presents bits [4p+3:4p] of row addr of logical block nib_blk, with p = nib_pos, on nib_rdata one cycle later. When that block is repaired, the nibble comes from the spare.
- R6: A narrow write (nib_en=1, nib_we=1, wide_en=0) changes only bits [4p+3:4p] of row addr in logical block nib_blk, so every other nibble and block keeps its value. A write to the repaired block goes to the spare only.
- R7: When repair is off, the spare is neither written nor read. All reads return the primary blocks, whatever cfg_idx held.
- R8: When wide_en and nib_en are both high, only the wide access takes place. A narrow write in that cycle stores nothing, and nib_rdata keeps its value.
- R9: wide_rdata changes only after a wide read. nib_rdata changes only after a narrow read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load the repair register |
| cfg_en | input | 1 | Repair enable value to load |
| cfg_idx | input | 2 | Repaired logical block value to load |
| addr | input | 5 | Row address shared by both ports |
| wide_en | input | 1 | Wide port access |
| wide_we | input | 1 | Wide port write (1) or read (0) |
| wide_wdata | input | 64 | Wide write data, 16 bits per logical block |
| wide_rdata | output | 64 | Wide read data, one cycle after the read |
| nib_en | input | 1 | Narrow port access |
| nib_we | input | 1 | Narrow port write (1) or read (0) |
| nib_blk | input | 2 | Logical block for the narrow access |
| nib_pos | input | 2 | Nibble position within the block |
| nib_wdata | input | 4 | Narrow write data |
| nib_rdata | output | 4 | Narrow read data, one cycle after the read |

## Verification
The wide and narrow ports can both be requested in one cycle. A repair-register load can also land in the same cycle as a write to the block it moves. The bench causes both on purpose. It raises nib_en together with wide_en in directed cycles and in a long random phase, and it reloads the register between and during traffic. A behavioural model applies the old repair setting to the access in the load cycle, and the new setting from the next cycle. On every clock the model's wide and nibble outputs are compared with the design's, bit by bit, wherever the model knows the stored value.

// File: rtl/spare_steer_ram.sv
module spare_steer_ram #(
  parameter int BLK_W = 16,
  parameter int ROWS  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_load,
  input  logic                          cfg_en,
  input  logic [1:0]                    cfg_idx,
  input  logic [$clog2(ROWS)-1:0]       addr,
  input  logic                          wide_en,
  input  logic                          wide_we,
  input  logic [4*BLK_W-1:0]            wide_wdata,
  output logic [4*BLK_W-1:0]            wide_rdata,
  input  logic                          nib_en,
  input  logic                          nib_we,
  input  logic [1:0]                    nib_blk,
  input  logic [$clog2(BLK_W/4)-1:0]    nib_pos,
  input  logic [3:0]                    nib_wdata,
  output logic [3:0]                    nib_rdata
);
  localparam int NIBS = BLK_W / 4;

  logic       rep_on;
  logic [1:0] rep_blk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rep_on  <= 1'b0;
      rep_blk <= 2'd0;
    end else if (cfg_load) begin
      rep_on  <= cfg_en;
      rep_blk <= cfg_idx;
    end

  wire wide_wr = wide_en && wide_we;
  wire wide_rd = wide_en && !wide_we;
  wire nib_go  = nib_en && !wide_en;
  wire nib_wr  = nib_go && nib_we;
  wire nib_rd  = nib_go && !nib_we;

  logic [BLK_W-1:0] lbus [4];
  logic [3:0]       lwe;
  logic [BLK_W-1:0] prow [4];
  logic [BLK_W-1:0] lane [4];
  logic [3:0]       pnib [4];
  logic [BLK_W-1:0] srow;
  logic [3:0]       snib;

  for (genvar b = 0; b < 4; b++) begin : g_blk
    logic [BLK_W-1:0] mem [ROWS];
    wire moved = rep_on && (rep_blk == 2'(b));
    wire pwe   = lwe[b] && !moved;

    assign lbus[b] = wide_en ? wide_wdata[b*BLK_W +: BLK_W] : {NIBS{nib_wdata}};
    assign lwe[b]  = wide_wr || (nib_wr && (nib_blk == 2'(b)));

    always_ff @(posedge clk)
      if (pwe) begin
        if (wide_en) mem[addr] <= lbus[b];
        else         mem[addr][{nib_pos, 2'b00} +: 4] <= nib_wdata;
      end

    assign prow[b] = mem[addr];
    assign pnib[b] = prow[b][{nib_pos, 2'b00} +: 4];
    assign lane[b] = moved ? srow : prow[b];
  end

  logic [BLK_W-1:0] spare [ROWS];
  wire [BLK_W-1:0] sbus = lbus[rep_blk];
  wire             swe  = rep_on && lwe[rep_blk];

  always_ff @(posedge clk)
    if (swe) begin
      if (wide_en) spare[addr] <= sbus;
      else         spare[addr][{nib_pos, 2'b00} +: 4] <= nib_wdata;
    end

  assign srow = spare[addr];
  assign snib = srow[{nib_pos, 2'b00} +: 4];

  wire [2:0] nsel = (rep_on && (rep_blk == nib_blk)) ? 3'd4 : {1'b0, nib_blk};
  logic [3:0] nib_mux;
  always_comb
    case (nsel)
      3'd0:    nib_mux = pnib[0];
      3'd1:    nib_mux = pnib[1];
      3'd2:    nib_mux = pnib[2];
      3'd3:    nib_mux = pnib[3];
      default: nib_mux = snib;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wide_rdata <= '0;
      nib_rdata  <= '0;
    end else begin
      if (wide_rd) wide_rdata <= {lane[3], lane[2], lane[1], lane[0]};
      if (nib_rd)  nib_rdata  <= nib_mux;
    end

  assert_reset_off_R1: assert property (@(posedge clk)
    !rst_n |=> (!rep_on && wide_rdata == '0 && nib_rdata == '0));

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable({rep_on, rep_blk}));

  assert_wide_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wide_en && !wide_we) |=> $stable(wide_rdata));

  assert_wide_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_en || !nib_en || nib_we) |=> $stable(nib_rdata));

  assert_one_writer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_on && wide_wr) |-> swe);
endmodule

// File: tb/test_spare_steer_ram.sv
module test_spare_steer_ram;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_load = 0, cfg_en = 0;
  logic [1:0]  cfg_idx = 0;
  logic [4:0]  addr = 0;
  logic        wide_en = 0, wide_we = 0;
  logic [63:0] wide_wdata = 0;
  logic [63:0] wide_rdata;
  logic        nib_en = 0, nib_we = 0;
  logic [1:0]  nib_blk = 0, nib_pos = 0;
  logic [3:0]  nib_wdata = 0;
  logic [3:0]  nib_rdata;

  always #(PERIOD/2) clk = ~clk;

  spare_steer_ram i_spare_steer_ram (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_en(cfg_en), .cfg_idx(cfg_idx),
    .addr(addr), .wide_en(wide_en), .wide_we(wide_we), .wide_wdata(wide_wdata),
    .wide_rdata(wide_rdata), .nib_en(nib_en), .nib_we(nib_we), .nib_blk(nib_blk),
    .nib_pos(nib_pos), .nib_wdata(nib_wdata), .nib_rdata(nib_rdata));

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] mp [4][32];
  logic [15:0] ms [32];
  bit          m_on = 0;
  int          m_blk = 0;
  logic [63:0] ew = 0;
  logic [3:0]  en = 0;

  initial begin
    for (int b = 0; b < 4; b++) for (int r = 0; r < 32; r++) mp[b][r] = 'x;
    for (int r = 0; r < 32; r++) ms[r] = 'x;
  end

  function automatic bit hit(int b);
    return m_on && (m_blk == b);
  endfunction

  task automatic model_step();
    int a = addr;
    if (wide_en) begin
      for (int b = 0; b < 4; b++) begin
        if (wide_we) begin
          if (hit(b)) ms[a] = wide_wdata[b*16 +: 16];
          else        mp[b][a] = wide_wdata[b*16 +: 16];
        end else
          ew[b*16 +: 16] = hit(b) ? ms[a] : mp[b][a];
      end
    end else if (nib_en) begin
      if (nib_we) begin
        if (hit(nib_blk)) ms[a][nib_pos*4 +: 4] = nib_wdata;
        else              mp[nib_blk][a][nib_pos*4 +: 4] = nib_wdata;
      end else
        en = hit(nib_blk) ? ms[a][nib_pos*4 +: 4] : mp[nib_blk][a][nib_pos*4 +: 4];
    end
    if (cfg_load) begin
      m_on = cfg_en;
      m_blk = cfg_idx;
    end
  endtask

  task automatic compare(string tag);
    bit bad = 0;
    for (int i = 0; i < 64; i++)
      if (!$isunknown(ew[i]) && wide_rdata[i] !== ew[i]) bad = 1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s wide_rdata actual %h expected %h", tag, wide_rdata, ew);
    end
    bad = 0;
    for (int i = 0; i < 4; i++)
      if (!$isunknown(en[i]) && nib_rdata[i] !== en[i]) bad = 1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s nib_rdata actual %h expected %h", tag, nib_rdata, en);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
    cfg_load = 0; wide_en = 0; wide_we = 0; nib_en = 0; nib_we = 0;
  endtask

  task automatic cfg(bit e, int k, string tag);
    cfg_load = 1; cfg_en = e; cfg_idx = 2'(k);
    cyc(tag);
  endtask

  task automatic wwr(int a, logic [63:0] d, string tag);
    addr = 5'(a); wide_en = 1; wide_we = 1; wide_wdata = d;
    cyc(tag);
  endtask

  task automatic wrd(int a, string tag);
    addr = 5'(a); wide_en = 1; wide_we = 0;
    cyc(tag);
  endtask

  task automatic nwr(int a, int b, int p, logic [3:0] d, string tag);
    addr = 5'(a); nib_en = 1; nib_we = 1; nib_blk = 2'(b); nib_pos = 2'(p); nib_wdata = d;
    cyc(tag);
  endtask

  task automatic nrd(int a, int b, int p, string tag);
    addr = 5'(a); nib_en = 1; nib_we = 0; nib_blk = 2'(b); nib_pos = 2'(p);
    cyc(tag);
  endtask

  function automatic logic [63:0] pat(int r, int s);
    return {16'(r * 16'h1111 + s), 16'(r * 16'h0707 ^ s), 16'(16'hA5A5 + r + s), 16'(r << 4 | s)};
  endfunction

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after reset");

    for (int r = 0; r < 32; r++) wwr(r, pat(r, 1), "R4 fill");
    wrd(0, "R3 row0"); wrd(3, "R3 row3"); wrd(31, "R3 row31");
    nrd(3, 0, 0, "R5 b0p0"); nrd(3, 2, 3, "R5 b2p3"); nrd(31, 3, 1, "R5 b3p1");

    nwr(7, 1, 2, 4'h9, "R6 narrow write");
    wrd(7, "R6 only one nibble");

    cfg(1, 2, "R2 repair blk2");
    wrd(5, "R3 spare unknown lane");
    for (int r = 0; r < 32; r++) wwr(r, pat(r, 2), "R4 fill repaired");
    wrd(5, "R3 spare lane");
    nrd(5, 2, 1, "R5 from spare");
    nwr(5, 2, 0, 4'h3, "R6 spare nibble");
    wrd(5, "R6 spare nibble read");

    cfg(0, 2, "R7 repair off");
    wrd(5, "R7 primary untouched R4");
    nwr(9, 2, 1, 4'hE, "R7 write primary");
    cfg(1, 2, "R2 repair on again");
    wrd(9, "R7 spare not written");

    addr = 5'd9; wide_en = 1; wide_we = 0; nib_en = 1; nib_we = 1;
    nib_blk = 2'd0; nib_pos = 2'd0; nib_wdata = 4'h0;
    cyc("R8 wide read with narrow write");
    nrd(9, 0, 0, "R8 narrow dropped");
    addr = 5'd4; wide_en = 1; wide_we = 0; nib_en = 1; nib_we = 0; nib_blk = 2'd1;
    cyc("R8 narrow read dropped");

    cyc("R9 idle"); cyc("R9 idle");
    nrd(4, 3, 2, "R9 wide holds");

    for (int k = 0; k < 4; k++) begin
      cfg(1, k, "R2 sweep");
      for (int r = 0; r < 32; r++) wwr(r, pat(r, 8 + k), "R4 sweep fill");
      for (int r = 0; r < 32; r += 5) wrd(r, "R3 sweep");
      for (int p = 0; p < 4; p++) nrd(11, k, p, "R5 sweep");
    end

    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      addr = 5'($urandom);
      if (op == 0) begin
        cfg_load = 1; cfg_en = 1'($urandom); cfg_idx = 2'($urandom);
      end
      if (op < 4) begin
        wide_en = 1; wide_we = 1'($urandom);
        wide_wdata = {$urandom, $urandom};
      end
      if (op >= 2) begin
        nib_en = 1; nib_we = 1'($urandom);
        nib_blk = 2'($urandom); nib_pos = 2'($urandom); nib_wdata = 4'($urandom);
      end
      cyc("R8 R6 R3 random");
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule